// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block takes two IEEE 754 binary operands and returns the smaller or the larger of them, together with an invalid-operation flag. One datapath serves four operations: legacy minimum, legacy maximum, and the IEEE 754-2008 minNum and maxNum operations. A per-transfer control bit picks min or max, and a second bit picks legacy or IEEE NaN handling. The operand format is set at build time by a parameter: single precision (8-bit exponent) or double precision (11-bit exponent).

The unit does more than compare and select. It treats quiet and signalling NaNs differently in the two modes. It orders negative zero below positive zero. It can flush denormal inputs to a zero of the same sign before the comparison. It can return a canonical quiet NaN in place of a propagated one. Operands and their control bits enter through a valid/ready port, and results leave through a second valid/ready port. With the output stage built in (the default), a transfer accepted on one edge shows up on the output on the next edge. The result and flag stay fixed while the consumer holds `out_ready` low. `in_ready` is high only when the output register is empty or is being drained in the same cycle. A producer may hold `in_valid` with its data for as long as it likes. A transfer happens only on a clock edge where `in_valid` and `in_ready` are both high.

Top module: `fp_minmax_unit`

## Requirements
- R1: With no NaN present, operands are ordered by sign first (negative below positive) and then by magnitude. The magnitude ordering is reversed when both are negative. `sel_min`=1 returns the smaller operand and `sel_min`=0 returns the larger.
- R2: Negative zero (sign 1, all other bits 0) is ordered below positive zero (all bits 0): min of the two returns negative zero and max returns positive zero, whatever their order at the inputs.
- R3: With `ieee_mode`=1, if one operand is a quiet NaN (exponent all ones, top mantissa bit 1) and the other is not a NaN, the result is the non-NaN operand.
- R4: With `ieee_mode`=0, if either operand is any NaN, the result is the first NaN operand (`op_a` before `op_b`) with its top mantissa bit forced to 1 and all other bits kept.
- R5: In either mode, a signalling NaN (exponent all ones, top mantissa bit 0, mantissa non-zero) on either input, or NaNs on both inputs, yields the propagated NaN of R4, even with `ieee_mode`=1.
- R6: When a NaN is propagated and `dflt_nan`=1, the result is the canonical quiet NaN: sign 0, exponent all ones, top mantissa bit 1, other bits 0 (0x7FC00000 in single precision).
- R7: `invalid` is 1 exactly when either operand is a signalling NaN, in both modes. Otherwise it is 0.
- R8: With `ftz_en`=1, each denormal input (exponent 0, mantissa non-zero) is replaced by a zero of the same sign before the comparison, and that zero is what the unit returns. With `ftz_en`=0, denormals are ordered as ordinary numbers.
- R9: Infinities order as ordinary values: +infinity is above every finite value and -infinity is below every finite value.
- R10: With the output stage present, the result of an accepted transfer appears with `out_valid`=1 one cycle later. While `out_valid`=1 and `out_ready`=0, `out_valid`, `result` and `invalid` hold their values and `in_ready` is 0.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and control bits are presented |
| in_ready | output | 1 | Unit can accept a transfer this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sel_min | input | 1 | 1 = minimum, 0 = maximum |
| ieee_mode | input | 1 | 1 = minNum/maxNum NaN rules, 0 = legacy rules |
| ftz_en | input | 1 | Flush denormal inputs to signed zero |
| dflt_nan | input | 1 | Return canonical quiet NaN when a NaN propagates |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | W | Selected value or propagated NaN |
| invalid | output | 1 | Invalid-operation flag (signalling NaN input) |

## Verification
Four properties are checked on every cycle against the operands captured at each accepted transfer. The invalid flag must track whether a signalling NaN was captured. A signalling NaN must never appear on the output. A pair of opposite-signed zeros must resolve by the min/max select. The output must stay stable under back-pressure. Other behaviours can only be shown by the bench's directed scenarios, because each needs a specific operand pair and an expected word: the order of magnitudes for negative operands, which NaN gets chosen and quieted, the IEEE-mode choice of the number over a quiet NaN, canonical NaN substitution, the effect of flushing denormals, and the placement of infinities.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  // Classification of one operand after optional denormal flushing.
  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
    logic is_denorm;
  } fpmm_class_t;

  function automatic int fpmm_width(input bit dbl);
    return dbl ? 64 : 32;
  endfunction

  function automatic int fpmm_exp_width(input bit dbl);
    return dbl ? 11 : 8;
  endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int W  = 32,
  parameter int EW = 8
) (
  input  logic [W-1:0] op,
  input  logic         ftz,
  output logic [W-1:0] val,
  output fpmm_class_t  cls
);
  localparam int MW = W - EW - 1;

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic          exp_max;
  logic          exp_min;
  logic          man_nz;

  assign exp_f   = op[W-2:MW];
  assign man_f   = op[MW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls.is_nan    = exp_max & man_nz;
    cls.is_qnan   = exp_max & man_f[MW-1];
    cls.is_snan   = exp_max & man_nz & ~man_f[MW-1];
    cls.is_denorm = exp_min & man_nz;
    cls.is_zero   = exp_min & (~man_nz | ftz);
    if (ftz && exp_min && man_nz) begin
      val = {op[W-1], {(W-1){1'b0}}};
    end else begin
      val = op;
    end
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_below,
  output logic         b_below
);
  logic         sa;
  logic         sb;
  logic [W-2:0] ma;
  logic [W-2:0] mb;
  logic         mag_lt;
  logic         mag_gt;

  assign sa     = a[W-1];
  assign sb     = b[W-1];
  assign ma     = a[W-2:0];
  assign mb     = b[W-2:0];
  assign mag_lt = ma < mb;
  assign mag_gt = mb < ma;

  always_comb begin
    if (sa != sb) begin
      a_below = sa;
      b_below = sb;
    end else if (!sa) begin
      a_below = mag_lt;
      b_below = mag_gt;
    end else begin
      a_below = mag_gt;
      b_below = mag_lt;
    end
  end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
#(
  parameter int W  = 32,
  parameter int EW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fpmm_class_t  ca,
  input  fpmm_class_t  cb,
  input  logic         a_below,
  input  logic         b_below,
  input  logic         sel_min,
  input  logic         ieee_mode,
  input  logic         dflt_nan,
  output logic [W-1:0] res,
  output logic         invalid
);
  localparam int MW = W - EW - 1;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0] QUIET_BIT = {{(W-MW){1'b0}}, 1'b1, {(MW-1){1'b0}}};

  logic         any_nan;
  logic         keep_b;
  logic         keep_a;
  logic [W-1:0] first_nan;
  logic [W-1:0] numeric;

  assign any_nan   = ca.is_nan | cb.is_nan;
  assign keep_b    = ieee_mode & ca.is_qnan & ~cb.is_nan;
  assign keep_a    = ieee_mode & cb.is_qnan & ~ca.is_nan;
  assign first_nan = (ca.is_nan ? a : b) | QUIET_BIT;
  assign numeric   = sel_min ? (b_below ? b : a) : (a_below ? b : a);

  always_comb begin
    invalid = ca.is_snan | cb.is_snan;
    if (!any_nan)     res = numeric;
    else if (keep_b)  res = b;
    else if (keep_a)  res = a;
    else if (dflt_nan) res = CANON_NAN;
    else              res = first_nan;
  end
endmodule

// File: rtl/fpmm_stage.sv
module fpmm_stage #(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_res,
  input  logic         d_inv,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_res,
  output logic         q_inv
);
  generate
    if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] res_q;
      logic         inv_q;
      logic         take;

      assign in_ready = ~vld_q | out_ready;
      assign take     = in_valid & in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          inv_q <= 1'b0;
        end else begin
          if (take) begin
            vld_q <= 1'b1;
            res_q <= d_res;
            inv_q <= d_inv;
          end else if (out_ready) begin
            vld_q <= 1'b0;
          end
        end
      end

      assign out_valid = vld_q;
      assign q_res     = res_q;
      assign q_inv     = inv_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign q_res     = d_res;
      assign q_inv     = d_inv;
    end
  endgenerate
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
#(
  parameter bit DOUBLE     = 1'b0,
  parameter bit REGISTERED = 1'b1,
  localparam int W  = fpmm_width(DOUBLE),
  localparam int EW = fpmm_exp_width(DOUBLE)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sel_min,
  input  logic         ieee_mode,
  input  logic         ftz_en,
  input  logic         dflt_nan,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         invalid
);
  logic [1:0][W-1:0] raw;
  logic [1:0][W-1:0] flushed;
  fpmm_class_t       cls [2];
  logic              a_below;
  logic              b_below;
  logic [W-1:0]      sel_res;
  logic              sel_inv;

  assign raw[0] = op_a;
  assign raw[1] = op_b;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cls
      fpmm_classify #(.W(W), .EW(EW)) cls_i (
        .op  (raw[i]),
        .ftz (ftz_en),
        .val (flushed[i]),
        .cls (cls[i])
      );
    end
  endgenerate

  fpmm_order #(.W(W)) order_i (
    .a       (flushed[0]),
    .b       (flushed[1]),
    .a_below (a_below),
    .b_below (b_below)
  );

  fpmm_select #(.W(W), .EW(EW)) select_i (
    .a         (flushed[0]),
    .b         (flushed[1]),
    .ca        (cls[0]),
    .cb        (cls[1]),
    .a_below   (a_below),
    .b_below   (b_below),
    .sel_min   (sel_min),
    .ieee_mode (ieee_mode),
    .dflt_nan  (dflt_nan),
    .res       (sel_res),
    .invalid   (sel_inv)
  );

  fpmm_stage #(.W(W), .REGISTERED(REGISTERED)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (sel_res),
    .d_inv     (sel_inv),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (result),
    .q_inv     (invalid)
  );
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker #(
  parameter int W          = 32,
  parameter int EW         = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sel_min,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic         invalid
);
  localparam int MW = W - EW - 1;

  logic [W-1:0] obs_a;
  logic [W-1:0] obs_b;
  logic         obs_min;

  function automatic logic sig_nan(input logic [W-1:0] v);
    return (&v[W-2:MW]) && (|v[MW-1:0]) && !v[MW-1];
  endfunction

  function automatic logic plain_zero(input logic [W-1:0] v);
    return ~|v[W-2:0];
  endfunction

  generate
    if (REGISTERED) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          obs_a   <= '0;
          obs_b   <= '0;
          obs_min <= 1'b0;
        end else if (in_valid && in_ready) begin
          obs_a   <= op_a;
          obs_b   <= op_b;
          obs_min <= sel_min;
        end
      end

      // R10: held output under back-pressure
      assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(invalid)));
    end else begin : g_pass
      assign obs_a   = op_a;
      assign obs_b   = op_b;
      assign obs_min = sel_min;
    end
  endgenerate

  assert_invalid_tracks_snan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (invalid == (sig_nan(obs_a) || sig_nan(obs_b))));

  assert_no_snan_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sig_nan(result));

  assert_zero_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && plain_zero(obs_a) && plain_zero(obs_b) && (obs_a[W-1] != obs_b[W-1]))
      |-> (result == {obs_min, {(W-1){1'b0}}}));
endmodule

bind fp_minmax_unit fpmm_checker #(.W(W), .EW(EW), .REGISTERED(REGISTERED)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .sel_min   (sel_min),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/fp_minmax_unit_tb_top.sv
module fp_minmax_unit_tb_top;
  localparam int W = 32;

  localparam logic [W-1:0] P_ONE  = 32'h3F80_0000;
  localparam logic [W-1:0] N_ONE  = 32'hBF80_0000;
  localparam logic [W-1:0] P_TWO  = 32'h4000_0000;
  localparam logic [W-1:0] N_TWO  = 32'hC000_0000;
  localparam logic [W-1:0] P_ZERO = 32'h0000_0000;
  localparam logic [W-1:0] N_ZERO = 32'h8000_0000;
  localparam logic [W-1:0] P_INF  = 32'h7F80_0000;
  localparam logic [W-1:0] N_INF  = 32'hFF80_0000;
  localparam logic [W-1:0] QNAN1  = 32'h7FC0_0001;
  localparam logic [W-1:0] QNAN2  = 32'h7FC1_2345;
  localparam logic [W-1:0] SNAN1  = 32'h7F80_0005;
  localparam logic [W-1:0] SNAN2  = 32'hFF80_0010;
  localparam logic [W-1:0] P_DEN  = 32'h0000_0010;
  localparam logic [W-1:0] N_DEN  = 32'h8000_0010;
  localparam logic [W-1:0] CANON  = 32'h7FC0_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sel_min = 1'b0;
  logic         ieee_mode = 1'b0;
  logic         ftz_en = 1'b0;
  logic         dflt_nan = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] result;
  logic         invalid;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_minmax_unit #(.DOUBLE(1'b0), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .sel_min(sel_min), .ieee_mode(ieee_mode),
    .ftz_en(ftz_en), .dflt_nan(dflt_nan), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .invalid(invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transfer: drive at falling edge, accepted on the rising edge, sampled at the next falling edge.
  task automatic run_op(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic mn, input logic ie, input logic fz, input logic dn,
                        input logic [W-1:0] exp_res, input logic exp_inv);
    @(negedge clk);
    op_a = a; op_b = b; sel_min = mn; ieee_mode = ie; ftz_en = fz; dflt_nan = dn;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, {32'd0, result}, {32'd0, exp_res});
    check({tag, " invalid"}, {63'd0, invalid}, {63'd0, exp_inv});
  endtask

  task automatic t_reset;
    check("R11 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R11 in_ready after reset", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_ordering;
    run_op("R1 min(1,2)",   P_ONE, P_TWO, 1, 0, 0, 0, P_ONE, 0);
    run_op("R1 max(1,2)",   P_ONE, P_TWO, 0, 0, 0, 0, P_TWO, 0);
    run_op("R1 min(-1,-2)", N_ONE, N_TWO, 1, 0, 0, 0, N_TWO, 0);
    run_op("R1 max(-1,-2)", N_ONE, N_TWO, 0, 1, 0, 0, N_ONE, 0);
    run_op("R1 min(2,-1)",  P_TWO, N_ONE, 1, 1, 0, 0, N_ONE, 0);
  endtask

  task automatic t_zeros;
    run_op("R2 min(+0,-0)", P_ZERO, N_ZERO, 1, 0, 0, 0, N_ZERO, 0);
    run_op("R2 max(-0,+0)", N_ZERO, P_ZERO, 0, 1, 0, 0, P_ZERO, 0);
    run_op("R2 min(-0,+0)", N_ZERO, P_ZERO, 1, 1, 0, 0, N_ZERO, 0);
  endtask

  task automatic t_ieee_qnan;
    run_op("R3 minNum(qnan,1)", QNAN1, P_ONE, 1, 1, 0, 0, P_ONE, 0);
    run_op("R3 maxNum(2,qnan)", P_TWO, QNAN1, 0, 1, 0, 0, P_TWO, 0);
  endtask

  task automatic t_legacy_nan;
    run_op("R4 min(qnan,1)",   QNAN1, P_ONE, 1, 0, 0, 0, QNAN1, 0);
    run_op("R4 max(1,snan)",   P_ONE, SNAN1, 0, 0, 0, 0, 32'h7FC0_0005, 1);
  endtask

  task automatic t_snan;
    run_op("R5 minNum(snan,1)",     SNAN1, P_ONE, 1, 1, 0, 0, 32'h7FC0_0005, 1);
    run_op("R5 maxNum(qnan2,qnan)", QNAN2, QNAN1, 0, 1, 0, 0, QNAN2, 0);
    run_op("R7 minNum(qnan,snan)",  QNAN1, SNAN2, 1, 1, 0, 0, QNAN1, 1);
    run_op("R7 max(-snan,1)",       SNAN2, P_ONE, 0, 0, 0, 0, 32'hFFC0_0010, 1);
  endtask

  task automatic t_default_nan;
    run_op("R6 min(snan,1) dflt",  SNAN1, P_ONE, 1, 0, 0, 1, CANON, 1);
    run_op("R6 maxNum(qnan,qnan) dflt", QNAN2, QNAN1, 0, 1, 0, 1, CANON, 0);
  endtask

  task automatic t_ftz;
    run_op("R8 min(-den,+0) no ftz", N_DEN, P_ZERO, 1, 0, 0, 0, N_DEN, 0);
    run_op("R8 min(-den,+0) ftz",    N_DEN, P_ZERO, 1, 0, 1, 0, N_ZERO, 0);
    run_op("R8 max(+den,-den) ftz",  P_DEN, N_DEN, 0, 0, 1, 0, P_ZERO, 0);
    run_op("R8 max(+den,-den) no ftz", P_DEN, N_DEN, 0, 0, 0, 0, P_DEN, 0);
  endtask

  task automatic t_inf;
    run_op("R9 max(+inf,2)",   P_INF, P_TWO, 0, 0, 0, 0, P_INF, 0);
    run_op("R9 min(-2,-inf)",  N_TWO, N_INF, 1, 1, 0, 0, N_INF, 0);
    run_op("R9 min(+inf,-1)",  P_INF, N_ONE, 1, 0, 0, 0, N_ONE, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    op_a = P_ONE; op_b = P_TWO; sel_min = 1'b0; ieee_mode = 1'b0; ftz_en = 1'b0; dflt_nan = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 first result valid", {63'd0, out_valid}, 64'd1);
    check("R10 first result", {32'd0, result}, {32'd0, P_TWO});
    op_a = N_ONE; op_b = N_TWO; sel_min = 1'b1;
    @(negedge clk);
    check("R10 in_ready low while stalled", {63'd0, in_ready}, 64'd0);
    check("R10 result held", {32'd0, result}, {32'd0, P_TWO});
    @(negedge clk);
    check("R10 still held", {32'd0, result}, {32'd0, P_TWO});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result valid", {63'd0, out_valid}, 64'd1);
    check("R10 second result", {32'd0, result}, {32'd0, N_TWO});
    @(negedge clk);
    check("R10 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ordering();
    t_zeros();
    t_ieee_qnan();
    t_legacy_nan();
    t_snan();
    t_default_nan();
    t_ftz();
    t_inf();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule